// File: doc/BRIEF.md
# Sixteen-Bit Multi-Source Timer Channel

This block is one channel of a hardware timer. A 16-bit count advances on a tick taken from one of two sources. The first source is the system clock. The second is chosen per channel at build time: a divided clock or an external line-rate tick. The count is compared against a programmable target and against the 16-bit wrap point. Either event can set sticky status flags in the control word and can raise a one-cycle interrupt pulse. The pulse is raised either once per arming or on every event.

Software reaches three registers through a simple single-cycle read/write bus: count, control and target. A control write re-arms the channel and restarts the count. A control read returns the flags and then clears the two event flags.

A synchronisation mode links the count to an external blanking input. On the two channel kinds driven by the fast or line clock, it can pause the count while blanking is high, or zero it when blanking falls. On the divide-by-eight channel kind, it can halt the count.

Top module: `rc_timer_channel`

## Requirements
- R1: After reset the count, control word and target all read 0, and `irq` is low. Bus addresses: 0 is the count, 1 is the control word, 2 is the target, and 3 reads 0.
- R2: With control bit 8 clear, the count advances by one every clock. On a tick at 0xFFFF it wraps to 0 and sets control bit 12 (overflow flag).
- R3: A tick that takes the count to the target value sets control bit 11. If control bit 3 is set, the count becomes 0 on that tick instead of the target value; otherwise it goes on towards the wrap.
- R4: Control bit 4 enables the interrupt on the target event and control bit 5 enables it on the overflow event. An enabled event drives `irq` high for exactly the following cycle and sets control bit 10.
- R5: With control bit 6 clear, only the first enabled event after a control write produces a pulse. With bit 6 set, every enabled event produces one.
- R6: A control write stores bits 9:0 of `wdata`, clears bits 15:10, sets the count to 0, re-arms the one-shot interrupt and restarts the prescaler. No event is taken in that cycle.
- R7: A control read returns the current word. Bits 11 and 12 are then cleared at the clock edge, except that an event in the same cycle sets its flag again.
- R8: A count write loads `wdata` and overrides the increment in that cycle. A target write leaves the count unchanged; the new target is compared from the next cycle on.
- R9: With control bit 8 set, the tick for the pixel kind (CHAN_KIND 0) comes once every PIX_DIV clocks. For the eighth kind (CHAN_KIND 2) it comes once every SLOW_DIV clocks. In both cases the first tick falls PIX_DIV or SLOW_DIV cycles after the control write. For the line kind (CHAN_KIND 1), the tick is the `line_tick` input.
- R10: Kinds 0 and 1, with control bit 0 set and bits 2:1 = 0: the count holds in every cycle where `blank` is high.
- R11: Kinds 0 and 1, with bit 0 set and bits 2:1 = 1 or 2: the count becomes 0 at the edge where `blank` was high at the previous edge and is low now. With bits 2:1 = 3 the count runs freely.
- R12: Kind 2, with bit 0 set: bits 2:1 = 0 or 3 stop the count, and 1 or 2 let it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on control read) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register (combinational) |
| line_tick | input | 1 | External line-rate tick (line kind only) |
| blank | input | 1 | External blanking level |
| irq | output | 1 | Interrupt pulse |

## Verification
Two coincidences are the risky ones. The first is a control read that clears the event flags in the same cycle a target event sets bit 11 again. The bench provokes it by reading the control word every cycle for many cycles while the count reloads every ten ticks, so several reads land on a target tick. The second is a bus write meeting an increment: count and target writes are issued while the count is running. In both cases a behavioural model in the bench predicts `rdata` and `irq` for all three channel kinds at every clock, so the winner of each collision is judged cycle by cycle.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int RC_W = 16;

    localparam int KIND_PIXEL  = 0;
    localparam int KIND_LINE   = 1;
    localparam int KIND_EIGHTH = 2;

    localparam int MB_SYNC     = 0;
    localparam int MB_SEL_LO   = 1;
    localparam int MB_SEL_HI   = 2;
    localparam int MB_TGT_RST  = 3;
    localparam int MB_IRQ_TGT  = 4;
    localparam int MB_IRQ_OVF  = 5;
    localparam int MB_REGEN    = 6;
    localparam int MB_ALT_CLK  = 8;
    localparam int MB_IRQ_SEEN = 10;
    localparam int MB_HIT_TGT  = 11;
    localparam int MB_HIT_OVF  = 12;

    localparam logic [RC_W-1:0] MODE_WR_MASK = 16'h03FF;
    localparam logic [RC_W-1:0] CNT_MAX      = {RC_W{1'b1}};

    localparam logic [1:0] A_COUNT  = 2'd0;
    localparam logic [1:0] A_MODE   = 2'd1;
    localparam logic [1:0] A_TARGET = 2'd2;

    typedef struct packed {
        logic [RC_W-1:0] cnt;
        logic [RC_W-1:0] mode;
        logic [RC_W-1:0] tgt;
    } rc_state_t;
endpackage

// File: rtl/rc_tick_gen.sv
module rc_tick_gen
    import rc_pkg::*;
#(
    parameter int KIND     = KIND_PIXEL,
    parameter int PIX_DIV  = 5,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic use_alt,
    input  logic line_tick,
    output logic tick
);
    generate
        if (KIND == KIND_LINE) begin : g_line
            logic unused_line;
            assign unused_line = clk ^ rst_n ^ restart;
            assign tick = use_alt ? line_tick : 1'b1;
        end else begin : g_div
            localparam int DIV = (KIND == KIND_EIGHTH) ? SLOW_DIV : PIX_DIV;
            localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
            logic [PW-1:0] pre_d, pre_q;
            logic          at_end;
            logic          unused_lt;

            assign unused_lt = line_tick;

            always_comb begin
                at_end = (pre_q == PW'(DIV - 1));
                if (restart || !use_alt) begin
                    pre_d = '0;
                end else if (at_end) begin
                    pre_d = '0;
                end else begin
                    pre_d = pre_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end

            assign tick = use_alt ? at_end : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rc_sync_ctl.sv
module rc_sync_ctl
    import rc_pkg::*;
#(
    parameter int KIND = KIND_PIXEL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank,
    input  logic       sync_en,
    input  logic [1:0] sync_sel,
    output logic       hold,
    output logic       zero
);
    localparam bit IS_EIGHTH = (KIND == KIND_EIGHTH);

    logic blank_d, blank_q;
    logic unblank;

    always_comb begin
        blank_d = blank;
        unblank = blank_q && !blank;
        if (IS_EIGHTH) begin
            hold = sync_en && ((sync_sel == 2'd0) || (sync_sel == 2'd3));
            zero = 1'b0;
        end else begin
            hold = sync_en && (sync_sel == 2'd0) && blank;
            zero = sync_en && ((sync_sel == 2'd1) || (sync_sel == 2'd2)) && unblank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blank_q <= 1'b0;
        end else begin
            blank_q <= blank_d;
        end
    end
endmodule

// File: rtl/rc_irq_ctl.sv
module rc_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic regen,
    input  logic want,
    output logic irq
);
    logic fired_d, fired_q;
    logic irq_d, irq_q;

    always_comb begin
        irq_d   = want && (regen || !fired_q);
        fired_d = rearm ? 1'b0 : (fired_q || irq_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            fired_q <= fired_d;
            irq_q   <= irq_d;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/rc_timer_channel.sv
module rc_timer_channel
    import rc_pkg::*;
#(
    parameter int CHAN_KIND = KIND_PIXEL,
    parameter int PIX_DIV   = 5,
    parameter int SLOW_DIV  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [RC_W-1:0] wdata,
    output logic [RC_W-1:0] rdata,
    input  logic            line_tick,
    input  logic            blank,
    output logic            irq
);
    rc_state_t       st_d, st_q;
    logic            wr_cnt, wr_mode, wr_tgt, rd_mode;
    logic            tick, hold, zero, advance;
    logic            tgt_hit, ovf_hit, irq_want;
    logic [RC_W-1:0] cnt_inc;
    logic [RC_W-1:0] cnt_now, mode_now;

    rc_tick_gen #(
        .KIND     (CHAN_KIND),
        .PIX_DIV  (PIX_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (wr_mode),
        .use_alt   (st_q.mode[MB_ALT_CLK]),
        .line_tick (line_tick),
        .tick      (tick)
    );

    rc_sync_ctl #(
        .KIND (CHAN_KIND)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank    (blank),
        .sync_en  (st_q.mode[MB_SYNC]),
        .sync_sel (st_q.mode[MB_SEL_HI:MB_SEL_LO]),
        .hold     (hold),
        .zero     (zero)
    );

    rc_irq_ctl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .rearm (wr_mode),
        .regen (st_q.mode[MB_REGEN]),
        .want  (irq_want),
        .irq   (irq)
    );

    always_comb begin
        st_d    = st_q;
        wr_cnt  = wr_en && (addr == A_COUNT);
        wr_mode = wr_en && (addr == A_MODE);
        wr_tgt  = wr_en && (addr == A_TARGET);
        rd_mode = rd_en && !wr_en && (addr == A_MODE);

        advance  = tick && !hold && !zero && !wr_cnt && !wr_mode;
        cnt_inc  = st_q.cnt + 1'b1;
        tgt_hit  = advance && (cnt_inc == st_q.tgt);
        ovf_hit  = advance && (st_q.cnt == CNT_MAX);
        irq_want = (tgt_hit && st_q.mode[MB_IRQ_TGT]) ||
                   (ovf_hit && st_q.mode[MB_IRQ_OVF]);

        // count: control write, then count write, then sync zero, then tick
        if (wr_mode) begin
            st_d.cnt = '0;
        end else if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (zero) begin
            st_d.cnt = '0;
        end else if (advance) begin
            st_d.cnt = (tgt_hit && st_q.mode[MB_TGT_RST]) ? '0 : cnt_inc;
        end

        // control word: read clears first, events set after
        if (wr_mode) begin
            st_d.mode = wdata & MODE_WR_MASK;
        end else begin
            if (rd_mode) begin
                st_d.mode[MB_HIT_TGT] = 1'b0;
                st_d.mode[MB_HIT_OVF] = 1'b0;
            end
            if (tgt_hit) begin
                st_d.mode[MB_HIT_TGT] = 1'b1;
            end
            if (ovf_hit) begin
                st_d.mode[MB_HIT_OVF] = 1'b1;
            end
            if (irq_want) begin
                st_d.mode[MB_IRQ_SEEN] = 1'b1;
            end
        end

        if (wr_tgt) begin
            st_d.tgt = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            A_COUNT:  rdata = st_q.cnt;
            A_MODE:   rdata = st_q.mode;
            A_TARGET: rdata = st_q.tgt;
            default:  rdata = '0;
        endcase
    end

    assign cnt_now  = st_q.cnt;
    assign mode_now = st_q.mode;
endmodule

// File: rtl/rc_timer_checker.sv
module rc_timer_checker
    import rc_pkg::*;
#(
    parameter int KIND = KIND_PIXEL
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [1:0]      addr,
    input logic [RC_W-1:0] wdata,
    input logic            blank,
    input logic            irq,
    input logic [RC_W-1:0] cnt_now,
    input logic [RC_W-1:0] mode_now
);
    localparam bit NOT_EIGHTH = (KIND != KIND_EIGHTH);

    logic seen_q;
    logic blank_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            blank_prev <= 1'b0;
        end else begin
            blank_prev <= blank;
            if (wr_en && addr == A_MODE) begin
                seen_q <= 1'b0;
            end else if (irq) begin
                seen_q <= 1'b1;
            end
        end
    end

    assert_cnt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_COUNT) |=> (cnt_now == $past(wdata)));

    assert_mode_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MODE) |=> (cnt_now == '0 && mode_now[15:10] == '0));

    assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && seen_q) |-> mode_now[MB_REGEN]);

    assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mode_now[MB_IRQ_SEEN]);

    assert_blank_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (NOT_EIGHTH && !wr_en && mode_now[MB_SYNC] && mode_now[2:1] == 2'd0 && blank)
        |=> (cnt_now == $past(cnt_now)));

    assert_unblank_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (NOT_EIGHTH && !wr_en && mode_now[MB_SYNC] &&
         (mode_now[2:1] == 2'd1 || mode_now[2:1] == 2'd2) && blank_prev && !blank)
        |=> (cnt_now == '0));
endmodule

bind rc_timer_channel rc_timer_checker #(.KIND(CHAN_KIND)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .blank    (blank),
    .irq      (irq),
    .cnt_now  (cnt_now),
    .mode_now (mode_now)
);

// File: tb/rc_timer_channel_test.sv
module rc_timer_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd1;
    logic [15:0] wdata = '0;
    logic        line_tick = 1'b0;
    logic        blank = 1'b0;
    logic [15:0] rd [3];
    logic        irqv [3];

    int    errs = 0;
    int    checks = 0;
    int    cyc_cnt = 0;
    string tag = "R1";

    int m_cnt [3];
    int m_mode [3];
    int m_tgt [3];
    int m_pre [3];
    int m_fired [3];
    int m_irq [3];
    int m_bq [3];

    always #4 clk = ~clk;

    rc_timer_channel #(.CHAN_KIND(0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd[0]), .line_tick(line_tick), .blank(blank), .irq(irqv[0]));
    rc_timer_channel #(.CHAN_KIND(1)) uut_line (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd[1]), .line_tick(line_tick), .blank(blank), .irq(irqv[1]));
    rc_timer_channel #(.CHAN_KIND(2)) uut_eighth (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd[2]), .line_tick(line_tick), .blank(blank), .irq(irqv[2]));

    function automatic void model_step(int k);
        int  div = (k == 2) ? 8 : 5;
        int  md  = m_mode[k];
        bit  wrc = wr_en && addr == 2'd0;
        bit  wrm = wr_en && addr == 2'd1;
        bit  wrt = wr_en && addr == 2'd2;
        bit  rdm = rd_en && !wr_en && addr == 2'd1;
        bit  alt = md[8];
        bit  se  = md[0];
        int  ss  = (md >> 1) & 3;
        bit  tk, hold, zero, adv, te, oe, want, fire;
        int  nx;
        if (k == 1) tk = alt ? line_tick : 1'b1;
        else        tk = alt ? (m_pre[k] == div - 1) : 1'b1;
        if (k == 2) begin
            hold = se && (ss == 0 || ss == 3);
            zero = 1'b0;
        end else begin
            hold = se && ss == 0 && blank;
            zero = se && (ss == 1 || ss == 2) && m_bq[k] != 0 && !blank;
        end
        adv  = tk && !hold && !zero && !wrc && !wrm;
        nx   = (m_cnt[k] + 1) & 'hFFFF;
        te   = adv && nx == m_tgt[k];
        oe   = adv && m_cnt[k] == 'hFFFF;
        want = (te && md[4]) || (oe && md[5]);
        fire = want && (md[6] || m_fired[k] == 0);
        m_irq[k]   = fire;
        m_fired[k] = wrm ? 0 : (m_fired[k] != 0 || fire);
        if (wrm) m_pre[k] = 0;
        else if (alt) m_pre[k] = (m_pre[k] == div - 1) ? 0 : m_pre[k] + 1;
        else m_pre[k] = 0;
        if (wrm) m_cnt[k] = 0;
        else if (wrc) m_cnt[k] = wdata;
        else if (zero) m_cnt[k] = 0;
        else if (adv) m_cnt[k] = (te && md[3]) ? 0 : nx;
        if (wrm) m_mode[k] = wdata & 'h3FF;
        else begin
            if (rdm) m_mode[k] = m_mode[k] & ~('h1800);
            if (te) m_mode[k] = m_mode[k] | 'h0800;
            if (oe) m_mode[k] = m_mode[k] | 'h1000;
            if (want) m_mode[k] = m_mode[k] | 'h0400;
        end
        if (wrt) m_tgt[k] = wdata;
        m_bq[k] = blank;
    endfunction

    initial begin
        for (int k = 0; k < 3; k++) begin
            m_cnt[k] = 0; m_mode[k] = 0; m_tgt[k] = 0; m_pre[k] = 0;
            m_fired[k] = 0; m_irq[k] = 0; m_bq[k] = 0;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        for (int k = 0; k < 3; k++) begin
            if (!rst_n) begin
                m_cnt[k] = 0; m_mode[k] = 0; m_tgt[k] = 0; m_pre[k] = 0;
                m_fired[k] = 0; m_irq[k] = 0; m_bq[k] = 0;
            end else begin
                model_step(k);
            end
        end
        if (cyc_cnt > 20000) begin
            errs++;
            $display("FAIL watchdog %s: run did not finish, cycle=%0d expected below 20000", tag, cyc_cnt);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // compare every instance at the falling edge, between input updates
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            int exp_rd;
            case (addr)
                2'd0: exp_rd = m_cnt[k];
                2'd1: exp_rd = m_mode[k];
                2'd2: exp_rd = m_tgt[k];
                default: exp_rd = 0;
            endcase
            checks++;
            if (rd[k] !== exp_rd[15:0]) begin
                errs++;
                $display("FAIL %s kind %0d rdata addr %0d = %h expected %h", tag, k, addr, rd[k], exp_rd[15:0]);
            end
            checks++;
            if (irqv[k] !== m_irq[k][0]) begin
                errs++;
                $display("FAIL %s kind %0d irq = %b expected %b", tag, k, irqv[k], m_irq[k][0]);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd_mode(int n);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = 2'd1;
        repeat (n) @(posedge clk);
        #1;
        rd_en = 1'b0; addr = 2'd0;
    endtask

    task automatic blank_run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            blank = ((i / 6) % 2) == 1;
        end
        @(posedge clk); #1;
        blank = 1'b0;
    endtask

    initial begin
        // R1: reset values through every address
        tag = "R1";
        idle(2); #1; addr = 2'd2;
        idle(1); #1; addr = 2'd3;
        idle(1); #1; addr = 2'd0; rst_n = 1'b1;

        tag = "R2";
        idle(25);
        wr(2'd0, 16'hFFF8);
        idle(14);
        rd_mode(1);
        rd_mode(2);

        tag = "R4";
        wr(2'd1, 16'h0020);
        wr(2'd0, 16'hFFFB);
        idle(12);
        rd_mode(1);

        tag = "R3 R5";
        wr(2'd2, 16'd10);
        wr(2'd1, 16'h0018);
        idle(40);
        rd_mode(1);

        tag = "R5";
        wr(2'd1, 16'h0058);
        idle(40);

        // R7: reads collide with target reloads
        tag = "R7";
        rd_mode(25);

        tag = "R3";
        wr(2'd1, 16'h0000);
        idle(20);
        rd_mode(1);

        tag = "R8";
        wr(2'd2, 16'd40);
        idle(5);
        wr(2'd0, 16'd38);
        idle(4);
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'h0007);
        wr(2'd2, 16'd9);
        idle(6);

        tag = "R6";
        wr(2'd1, 16'hFFFF);
        idle(20);
        rd_mode(1);

        tag = "R9";
        wr(2'd1, 16'h0130);
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            line_tick = (i % 7) == 0;
        end
        @(posedge clk); #1; line_tick = 1'b0;

        tag = "R10 R12";
        wr(2'd1, 16'h0001);
        blank_run(40);

        tag = "R11 R12";
        wr(2'd1, 16'h0003);
        blank_run(40);
        wr(2'd1, 16'h0005);
        blank_run(40);

        tag = "R11 R12";
        wr(2'd1, 16'h0007);
        blank_run(30);

        idle(3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule